// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Generator

This block is the timing engine of a master on a single-wire, open-drain bus. It can only pull the shared line low, through an output enable that drives an open-drain pad, and it reads the line back through a synchronizer. Three operations are available: a bus initialization, a write time slot for one bit value, and a read time slot. The host selects one with an operation code and a one-cycle start strobe. It then waits for the busy flag to drop and reads either the presence flag or the received bit.

All durations are counted in microseconds. A parameterized clock divider turns the system clock into a one-microsecond tick, so the same block runs at any clock that is an integer number of megahertz. Before any sample is taken, the line input passes through a synchronizer chain of parameterized depth (two flops by default). Each timing point is a parameter in microseconds.

Top module: `swire_slot_master`

## Requirements
- R1: Reset state and start. After reset, busy, line_oe, presence and rd_bit are 0. A start strobe taken while idle, with cmd_op 0 (initialization), 1 (write) or 2 (read), raises busy and line_oe at the next clock edge.
- R2: In an initialization, line_oe stays high for exactly T_RST_LOW_US (480) microseconds, which is T_RST_LOW_US×CLK_DIV clocks.
- R3: The synchronized line is sampled T_PRES_US (70) microseconds after the reset low is released. presence becomes 1 if the line is low at that point and 0 otherwise. A slave low pulse that ends before that point, or begins after it, gives 0.
- R4: An initialization holds busy for T_RST_LOW_US + T_RST_REL_US (480 + 480) microseconds.
- R5: A write slot with cmd_wbit 0 holds line_oe high for the whole T_SLOT_US (70) microsecond slot.
- R6: A write slot with cmd_wbit 1, and any read slot, holds line_oe high for T_SHORT_US (6) microseconds and then releases the line.
- R7: A write or read slot holds busy for T_SLOT_US + T_REC_US (70 + 5) microseconds. line_oe is low for the final T_REC_US microseconds and is never high while busy is low.
- R8: A read slot samples the synchronized line T_SAMPLE_US (15) microseconds after the slot start, while the master has released the line. rd_bit takes the sampled level.
- R9: presence changes only when an initialization completes, and rd_bit changes only when a read slot completes. Other operations, and the middle of a slot, leave both unchanged.
- R10: A start strobe given while busy is ignored. The timing and the results of the running operation are unaffected.
- R11: The microsecond tick fires exactly once every CLK_DIV clocks while busy and never while idle.
- R12: cmd_op 3 is reserved. A start strobe that carries it leaves the block idle, with line_oe low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle start strobe |
| cmd_op | input | 2 | Operation: 0 initialization, 1 write, 2 read, 3 reserved |
| cmd_wbit | input | 1 | Bit value for a write slot |
| line_in | input | 1 | Raw level of the bus line |
| busy | output | 1 | Operation in progress |
| presence | output | 1 | Presence result of the last initialization |
| rd_bit | output | 1 | Bit received in the last read slot |
| line_oe | output | 1 | 1 pulls the line low through the open-drain pad |

## Verification
The bench builds the block with CLK_DIV set to 3 and keeps the default microsecond timing points. Every duration can therefore be checked as an exact count of clocks, and a full initialization still takes under three thousand cycles. With that short cycle count, the bench sweeps the slave's low window across each sampling point, with margins of a few microseconds on either side. It covers the read sample at 15 microseconds and the presence sample at 70 microseconds after release, for both bit values and for presence present and absent. It also injects strobes in the middle of an operation and a strobe with the reserved code.

// File: rtl/swire_pkg.sv
package swire_pkg;

  typedef enum logic [1:0] {
    OP_INIT  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_NONE  = 2'd3
  } sw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RST_LOW  = 3'd1,
    ST_RST_WAIT = 3'd2,
    ST_SLOT     = 3'd3,
    ST_REC      = 3'd4
  } sw_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Low time of a slot in microseconds: a write of 0 holds for the whole slot.
  function automatic int unsigned hold_low_us(input sw_op_e op, input logic wbit,
                                              input int unsigned short_us,
                                              input int unsigned slot_us);
    return (op == OP_WRITE && !wbit) ? slot_us : short_us;
  endfunction

  // True on the tick that completes microsecond number 'mark' of a phase.
  function automatic logic at_mark(input logic tick, input int unsigned us_now,
                                   input int unsigned mark);
    return tick && (us_now == mark - 1);
  endfunction

endpackage

// File: rtl/swire_tick_gen.sv
module swire_tick_gen #(
  parameter int unsigned CLK_DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned DIV_W = $clog2((CLK_DIV > 1) ? CLK_DIV : 2);
  localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] div_q;

  assign tick = run && (div_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/swire_line_sync.sv
module swire_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/swire_us_timer.sv
module swire_us_timer #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] us_cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) us_cnt <= '0;
    else if (tick)     us_cnt <= us_cnt + 1'b1;
  end
endmodule

// File: rtl/swire_slot_fsm.sv
module swire_slot_fsm
  import swire_pkg::*;
#(
  parameter int unsigned CNT_W       = 9,
  parameter int unsigned T_RST_LOW_US = 480,
  parameter int unsigned T_PRES_US    = 70,
  parameter int unsigned T_RST_REL_US = 480,
  parameter int unsigned T_SLOT_US    = 70,
  parameter int unsigned T_REC_US     = 5,
  parameter int unsigned T_SHORT_US   = 6,
  parameter int unsigned T_SAMPLE_US  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_wbit,
  input  logic             tick,
  input  logic [CNT_W-1:0] us_cnt,
  input  logic             line_s,
  output logic             timer_clr,
  output logic             busy,
  output logic             line_oe,
  output logic             presence,
  output logic             rd_bit,
  output logic             done_evt,
  output logic             samp_evt
);
  sw_state_e   state;
  sw_op_e      cur_op;
  logic        cur_bit;
  logic        slot_rel;
  logic        pres_seen;
  logic        samp_bit;

  sw_op_e      req_op;
  int unsigned us_now;
  logic        accept;
  logic        ev_rst_rel, ev_pres, ev_rst_done;
  logic        ev_release, ev_rd_samp, ev_slot_end, ev_rec_done;

  assign req_op = sw_op_e'(cmd_op);
  assign us_now = 32'(us_cnt);
  assign accept = cmd_valid && (state == ST_IDLE) && (req_op != OP_NONE);

  always_comb begin
    ev_rst_rel  = (state == ST_RST_LOW)  && at_mark(tick, us_now, T_RST_LOW_US);
    ev_pres     = (state == ST_RST_WAIT) && at_mark(tick, us_now, T_PRES_US);
    ev_rst_done = (state == ST_RST_WAIT) && at_mark(tick, us_now, T_RST_REL_US);
    ev_release  = (state == ST_SLOT) &&
                  at_mark(tick, us_now, hold_low_us(cur_op, cur_bit, T_SHORT_US, T_SLOT_US));
    ev_rd_samp  = (state == ST_SLOT) && (cur_op == OP_READ) &&
                  at_mark(tick, us_now, T_SAMPLE_US);
    ev_slot_end = (state == ST_SLOT) && at_mark(tick, us_now, T_SLOT_US);
    ev_rec_done = (state == ST_REC)  && at_mark(tick, us_now, T_REC_US);
  end

  assign timer_clr = accept || ev_rst_rel || ev_slot_end;
  assign busy      = (state != ST_IDLE);
  assign line_oe   = (state == ST_RST_LOW) || ((state == ST_SLOT) && !slot_rel);
  assign done_evt  = ev_rst_done || ev_rec_done;
  assign samp_evt  = ev_pres || ev_rd_samp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_op    <= OP_INIT;
      cur_bit   <= 1'b0;
      slot_rel  <= 1'b0;
      pres_seen <= 1'b0;
      samp_bit  <= 1'b1;
      presence  <= 1'b0;
      rd_bit    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            cur_op    <= req_op;
            cur_bit   <= cmd_wbit;
            slot_rel  <= 1'b0;
            pres_seen <= 1'b0;
            state     <= (req_op == OP_INIT) ? ST_RST_LOW : ST_SLOT;
          end
        end
        ST_RST_LOW: begin
          if (ev_rst_rel) state <= ST_RST_WAIT;
        end
        ST_RST_WAIT: begin
          if (ev_pres) pres_seen <= !line_s;
          if (ev_rst_done) begin
            presence <= pres_seen;
            state    <= ST_IDLE;
          end
        end
        ST_SLOT: begin
          if (ev_release) slot_rel <= 1'b1;
          if (ev_rd_samp) samp_bit <= line_s;
          if (ev_slot_end) state <= ST_REC;
        end
        ST_REC: begin
          if (ev_rec_done) begin
            if (cur_op == OP_READ) rd_bit <= samp_bit;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swire_slot_master.sv
module swire_slot_master
  import swire_pkg::*;
#(
  parameter int unsigned CLK_DIV      = 50,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned T_RST_LOW_US = 480,
  parameter int unsigned T_PRES_US    = 70,
  parameter int unsigned T_RST_REL_US = 480,
  parameter int unsigned T_SLOT_US    = 70,
  parameter int unsigned T_REC_US     = 5,
  parameter int unsigned T_SHORT_US   = 6,
  parameter int unsigned T_SAMPLE_US  = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_wbit,
  input  logic       line_in,
  output logic       busy,
  output logic       presence,
  output logic       rd_bit,
  output logic       line_oe
);
  localparam int unsigned MAX_US = max3(T_RST_LOW_US, T_RST_REL_US, T_SLOT_US);
  localparam int unsigned CNT_W  = $clog2(MAX_US + 1);

  // Named internal events, observed by the bound checker.
  logic             tick_w;
  logic             done_w;
  logic             samp_w;
  logic             line_s;
  logic             timer_clr;
  logic [CNT_W-1:0] us_cnt;

  swire_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick_w)
  );

  swire_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  swire_us_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(timer_clr), .tick(tick_w), .us_cnt(us_cnt)
  );

  swire_slot_fsm #(
    .CNT_W(CNT_W), .T_RST_LOW_US(T_RST_LOW_US), .T_PRES_US(T_PRES_US),
    .T_RST_REL_US(T_RST_REL_US), .T_SLOT_US(T_SLOT_US), .T_REC_US(T_REC_US),
    .T_SHORT_US(T_SHORT_US), .T_SAMPLE_US(T_SAMPLE_US)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wbit(cmd_wbit), .tick(tick_w), .us_cnt(us_cnt), .line_s(line_s),
    .timer_clr(timer_clr), .busy(busy), .line_oe(line_oe), .presence(presence),
    .rd_bit(rd_bit), .done_evt(done_w), .samp_evt(samp_w)
  );
endmodule

// File: rtl/swire_slot_checker.sv
module swire_slot_checker #(
  parameter int unsigned CLK_DIV = 50
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       busy,
  input logic       presence,
  input logic       rd_bit,
  input logic       line_oe,
  input logic       tick_w,
  input logic       done_w,
  input logic       samp_w
);
  int unsigned gap;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy || tick_w) gap <= 0;
    else                           gap <= gap + 1;
  end

  p_start_drives_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op != 2'd3) |=> (busy && line_oe));

  p_oe_needs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> busy);

  p_done_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |-> !line_oe);

  p_sample_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    samp_w |-> (!line_oe && busy));

  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_w |=> ($stable(presence) && $stable(rd_bit)));

  p_busy_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && !done_w) |=> busy);

  p_tick_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tick_w |-> busy);

  p_tick_period_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tick_w |-> (gap == CLK_DIV - 1));

  p_reserved_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 2'd3) |=> (!busy && !line_oe));
endmodule

bind swire_slot_master swire_slot_checker #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .presence(presence), .rd_bit(rd_bit), .line_oe(line_oe),
  .tick_w(tick_w), .done_w(done_w), .samp_w(samp_w)
);

// File: tb/sim_swire_slot_master.sv
module sim_swire_slot_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 3;
  localparam int RST_LOW = 480, PRES = 70, RST_REL = 480;
  localparam int SLOT = 70, REC = 5, SHORT = 6, SAMPLE = 15;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [1:0] cmd_op;
  logic       cmd_wbit;
  logic       line_in;
  logic       busy, presence, rd_bit, line_oe;
  logic       slave_low;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  // Open-drain line with pullup: low if master or slave pulls.
  assign line_in = !(line_oe || slave_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  swire_slot_master #(.CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wbit(cmd_wbit), .line_in(line_in), .busy(busy), .presence(presence),
    .rd_bit(rd_bit), .line_oe(line_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Level of the slave window at microsecond 'mark' (windows keep wide margins).
  function automatic int low_at(input int from_us, input int to_us, input int mark);
    return (from_us < mark && to_us > mark) ? 1 : 0;
  endfunction

  int busy_n, oe_n, probe_v;
  logic first_busy, first_oe;

  // Runs one operation; slave pulls low in [from_us, to_us) after the start edge.
  task automatic run_op(input logic [1:0] op, input logic wb, input int from_us,
                        input int to_us, input int poke_cyc, input int probe_cyc);
    int n;
    @(negedge clk);
    cmd_op = op; cmd_wbit = wb; cmd_valid = 1'b1; slave_low = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0; busy_n = 0; oe_n = 0; probe_v = -1;
    first_busy = busy; first_oe = line_oe;
    while (busy && n < 10000) begin
      busy_n++;
      if (line_oe) oe_n++;
      if (n == probe_cyc) probe_v = int'(rd_bit);
      cmd_valid = (n == poke_cyc);
      cmd_op    = (n == poke_cyc) ? 2'd2 : op;
      n++;
      slave_low = (n >= from_us*DIV) && (n < to_us*DIV);
      @(negedge clk);
    end
    cmd_valid = 1'b0; slave_low = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int rd_exp, pres_exp, ends[6];
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_wbit = 1'b0; slave_low = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 busy after reset", int'(busy), 0);
    check("R1 line_oe after reset", int'(line_oe), 0);
    check("R1 presence after reset", int'(presence), 0);
    check("R1 rd_bit after reset", int'(rd_bit), 0);

    // R12: reserved code leaves the block idle
    @(negedge clk); cmd_op = 2'd3; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    check("R12 busy after reserved op", int'(busy), 0);
    check("R12 line_oe after reserved op", int'(line_oe), 0);

    // Initialization with a presence pulse covering the sample point
    run_op(2'd0, 1'b0, RST_LOW + 20, RST_LOW + 150, -1, -1);
    check("R1 busy rises on init start", int'(first_busy), 1);
    check("R1 line_oe rises on init start", int'(first_oe), 1);
    check("R2 reset low clocks", oe_n, RST_LOW*DIV);
    check("R4 init busy clocks", busy_n, (RST_LOW + RST_REL)*DIV);
    check("R3 presence seen", int'(presence), low_at(20, 150, PRES));

    // Presence pulse that ends early, then one that starts late
    run_op(2'd0, 1'b0, RST_LOW + 1, RST_LOW + 40, -1, -1);
    check("R3 early pulse missed", int'(presence), low_at(1, 40, PRES));
    run_op(2'd0, 1'b0, RST_LOW + 100, RST_LOW + 200, -1, -1);
    check("R3 late pulse missed", int'(presence), low_at(100, 200, PRES));

    // R10: strobe in the middle of an initialization
    run_op(2'd0, 1'b0, RST_LOW + 30, RST_LOW + 120, 100, -1);
    check("R10 init low unchanged by strobe", oe_n, RST_LOW*DIV);
    check("R10 init busy unchanged by strobe", busy_n, (RST_LOW + RST_REL)*DIV);
    check("R10 presence after strobe", int'(presence), 1);

    // Write slots
    run_op(2'd1, 1'b0, 1000, 1000, -1, -1);
    check("R1 busy rises on write start", int'(first_busy), 1);
    check("R5 write0 low clocks", oe_n, SLOT*DIV);
    check("R7 write0 busy clocks", busy_n, (SLOT + REC)*DIV);
    check("R9 presence kept over write", int'(presence), 1);
    check("R9 rd_bit kept over write", int'(rd_bit), 0);
    run_op(2'd1, 1'b1, 1000, 1000, -1, -1);
    check("R6 write1 low clocks", oe_n, SHORT*DIV);
    check("R7 write1 busy clocks", busy_n, (SLOT + REC)*DIV);

    // R8: sweep the slave window end across the read sample point
    ends = '{5, 10, 13, 17, 20, 40};
    foreach (ends[i]) begin
      int prev;
      prev = int'(rd_bit);
      rd_exp = 1 - low_at(1, ends[i], SAMPLE);
      run_op(2'd2, 1'b0, 1, ends[i], 50, 30*DIV);
      check("R8 read bit", int'(rd_bit), rd_exp);
      check("R6 read low clocks", oe_n, SHORT*DIV);
      check("R7 read busy clocks", busy_n, (SLOT + REC)*DIV);
      check("R9 rd_bit held mid slot", probe_v, prev);
      check("R10 read strobe ignored presence", int'(presence), 1);
    end
    // Late slave pulse and released line read as 1
    run_op(2'd2, 1'b0, 20, 40, -1, -1);
    check("R8 late pulse reads one", int'(rd_bit), 1 - low_at(20, 40, SAMPLE));
    run_op(2'd2, 1'b0, 3, 30, -1, -1);
    check("R8 held low reads zero", int'(rd_bit), 0);

    // R9: rd_bit unchanged by write and initialization
    run_op(2'd1, 1'b1, 1000, 1000, -1, -1);
    check("R9 rd_bit kept over write1", int'(rd_bit), 0);
    pres_exp = low_at(200, 300, PRES);
    run_op(2'd0, 1'b0, RST_LOW + 200, RST_LOW + 300, -1, -1);
    check("R9 rd_bit kept over init", int'(rd_bit), 0);
    check("R3 presence absent", int'(presence), pres_exp);
    run_op(2'd2, 1'b0, 1000, 1000, -1, -1);
    check("R9 presence kept over read", int'(presence), pres_exp);
    check("R8 released line reads one", int'(rd_bit), 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule